// File: doc/BRIEF.md
# Byte-Level I2C Bus Master with Phase-Coded Status

This block is a single-master I2C controller that software runs one bus operation at a time through four byte-wide registers. One control write asks for a START (which becomes a repeated START if a transaction is already open), the transfer of one byte, or a STOP. The block then drives the open-drain SCL and SDA lines, times every half bit from a programmable rate, and samples the acknowledge bit. When the operation ends it posts a status code that names the operation and its outcome, and raises the done flag.

The status code depends on the phase of the transaction. The first byte after a START or repeated START is treated as the slave address, and its least significant bit selects the direction. Every later byte is data in that direction. The done flag stays low from the accepted command until the operation finishes. It rises on the same clock edge that loads the new code, so a loop that polls the flag and then reads the status always sees the code for the operation just finished.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status register reads 0xF8 (prescaler 0), the control register reads 0x00, both bus lines are released and `irq` is low.
- R2: Register map: address 0 is control, 1 is data, 2 is bit rate, 3 is status/prescaler. Control bits: 7 is the done flag, 6 is the master-acknowledge enable, 5 is start, 4 is stop, 2 is enable and 0 is interrupt enable. With flag and enable set, start=1 requests a START and returns status 0x08 (0xA4 form), stop=1 requests a STOP (0x94 form), and neither sends one byte (0x84 form). Two kinds of write are ignored: a byte command while no transaction is open, and any register write while an operation is running.
- R3: Writing 1 to the flag bit clears the flag and starts the command. Writing 0 to it leaves the flag unchanged. The flag reads 0 from the command edge until the operation ends, and it rises on the same edge as the new status code.
- R4: A first byte with bit 0 = 0 (address for writing) reports 0x18 when the slave acknowledges and 0x20 when it does not.
- R5: A later byte in a write transaction reports 0x28 when acknowledged and 0x30 when not acknowledged.
- R6: A start request while a transaction is open performs a repeated START and reports 0x10.
- R7: A first byte with bit 0 = 1 reports 0x40 when acknowledged and 0x48 when not. In a read transaction, a later byte is shifted in MSB first and placed in the data register. It reports 0x50 if the master acknowledged it (control bit 6 set in the command) and 0x58 if not.
- R8: A STOP releases SDA while SCL is high, leaves both lines released, sets status 0xF8 and raises the flag. Whenever no transaction is open and no operation is running, the status is 0xF8 and both lines are released.
- R9: One half SCL period lasts 8 + rate·4^prescale clocks. START lasts 2 halves, repeated START 4, STOP 3 and a byte 18 (8 data bits and 1 acknowledge bit). The flag rises exactly that many clocks after the command edge.
- R10: Transmitted bytes go out MSB first. During a byte, SDA changes only while SCL is low. The acknowledge bit is sampled at the 9th rising edge of SCL.
- R11: `irq` is high exactly when both the flag and interrupt enable are 1.
- R12: The status register reads the code in bits 7:3, 0 in bit 2 and the prescaler in bits 1:0, so masking with 0xF8 yields the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
A wrong transaction phase shows up as a swapped address or data code on the flag edge that ends the affected byte, so it is visible at most 18 half periods after the command. If the half-period counter or the step counter goes wrong, the flag edge moves off the exact clock predicted from the rate formula, and the monitor measures that edge on every operation. A corrupted shift or bit-index path shows up as a wrong byte at the modelled slave at the end of a write, or as a wrong value in the data register after a read. A stuck hold state shows up as bus lines left driven after a STOP.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int HALF_W = 16;
  localparam int RATE_W = 8;
  localparam int PS_W   = 2;
  localparam int STEP_W = 5;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_RATE = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef enum logic [1:0] {OP_START, OP_RSTART, OP_STOP, OP_BYTE} op_e;

  localparam logic [7:0] ST_IDLE    = 8'hF8;
  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_DW_NACK = 8'h30;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_DR_ACK  = 8'h50;
  localparam logic [7:0] ST_DR_NACK = 8'h58;

  // Half of one SCL period in system clocks.
  function automatic logic [HALF_W-1:0] half_period(input logic [RATE_W-1:0] rate,
                                                     input logic [PS_W-1:0] ps);
    logic [HALF_W-1:0] scaled;
    scaled = HALF_W'(rate) << (2 * ps);
    return HALF_W'(8) + scaled;
  endfunction

  // Index of the final half-period step of each operation.
  function automatic logic [STEP_W-1:0] last_step(input op_e op);
    case (op)
      OP_START, OP_RSTART: return STEP_W'(3);
      OP_STOP:             return STEP_W'(2);
      default:             return STEP_W'(17);
    endcase
  endfunction

  // Code posted after a byte, from transaction phase, direction and acknowledge.
  function automatic logic [7:0] byte_status(input logic is_addr, input logic rd_dir,
                                             input logic acked);
    if (is_addr) return rd_dir ? (acked ? ST_AR_ACK : ST_AR_NACK)
                               : (acked ? ST_AW_ACK : ST_AW_NACK);
    return rd_dir ? (acked ? ST_DR_ACK : ST_DR_NACK)
                  : (acked ? ST_DW_ACK : ST_DW_NACK);
  endfunction
endpackage

// File: rtl/i2cm_half_timer.sv
module i2cm_half_timer
  import i2cm_pkg::*;
#(
  parameter int CW = HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  input  logic [PS_W-1:0]   ps,
  output logic              tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] half_len;

  assign half_len = CW'(half_period(rate, ps));
  assign tick     = run && (cnt == half_len - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  op_e        go_op,
  input  logic [7:0] go_tx,
  input  logic       go_rx,
  input  logic       go_mack,
  input  logic       tick,
  input  logic       sda_line,
  output logic       busy,
  output logic       done,
  output logic       byte_phase,
  output logic       scl_low,
  output logic       sda_low,
  output logic       ack_seen,
  output logic [7:0] rx_byte
);
  op_e               op;
  logic [STEP_W-1:0] step;
  logic [7:0]        tx;
  logic              rxm, mack, hold_scl, hold_sda;
  logic [3:0]        bit_idx;
  logic              at_last;

  assign bit_idx    = step[4:1];
  assign at_last    = (step == last_step(op));
  assign done       = busy && tick && at_last;
  assign byte_phase = busy && (op == OP_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; op <= OP_START; step <= '0; tx <= '0; rxm <= 1'b0; mack <= 1'b0;
      rx_byte <= '0; ack_seen <= 1'b0; hold_scl <= 1'b0; hold_sda <= 1'b0;
    end else if (go && !busy) begin
      busy <= 1'b1;
      op   <= go_op;
      step <= (go_op == OP_START) ? STEP_W'(2) : STEP_W'(0);
      tx   <= go_tx;
      rxm  <= go_rx;
      mack <= go_mack;
    end else if (busy && tick) begin
      if (op == OP_BYTE && !step[0]) begin
        if (step < STEP_W'(16)) rx_byte <= {rx_byte[6:0], sda_line};
        else                    ack_seen <= !sda_line;
      end
      if (at_last) begin
        busy     <= 1'b0;
        hold_scl <= (op != OP_STOP);
        hold_sda <= (op == OP_START) || (op == OP_RSTART);
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

  always_comb begin
    scl_low = hold_scl;
    sda_low = hold_sda;
    if (busy) begin
      case (op)
        OP_START, OP_RSTART: begin
          scl_low = (step == STEP_W'(0)) || (step == STEP_W'(3));
          sda_low = (step >= STEP_W'(2));
        end
        OP_STOP: begin
          scl_low = (step == STEP_W'(0));
          sda_low = (step != STEP_W'(2));
        end
        default: begin
          scl_low = !step[0];
          if (!bit_idx[3]) sda_low = !rxm && !tx[~bit_idx[2:0]];
          else             sda_low = rxm && mack;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int TIMER_W = HALF_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  input  logic       sda_in
);
  logic              flag, en_r, ie_r, acken_r;
  logic [7:0]        data_r;
  logic [RATE_W-1:0] rate_r;
  logic [PS_W-1:0]   ps_r;
  logic [4:0]        status_code;
  logic              txn_open, addr_phase, read_dir;
  op_e               cur_op, go_op;
  logic              cur_addr, cur_rx, cur_mack;
  logic              eng_busy, op_done, eng_ack, half_tick, byte_phase;
  logic [7:0]        eng_rx;
  logic              bus_wr, ctrl_wr, cmd_go, cmd_rx;
  logic [7:0]        next_code;

  assign bus_wr  = reg_wr && !eng_busy;
  assign ctrl_wr = bus_wr && (reg_addr == A_CTRL);
  assign cmd_go  = ctrl_wr && reg_wdata[7] && reg_wdata[2]
                   && (reg_wdata[5] || reg_wdata[4] || txn_open);
  assign go_op   = reg_wdata[5] ? (txn_open ? OP_RSTART : OP_START)
                 : reg_wdata[4] ? OP_STOP : OP_BYTE;
  assign cmd_rx  = !addr_phase && read_dir;
  assign irq     = flag && ie_r;

  i2cm_half_timer #(.CW(TIMER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .rate(rate_r), .ps(ps_r), .tick(half_tick)
  );

  i2cm_bit_engine u_engine (
    .clk(clk), .rst_n(rst_n), .go(cmd_go), .go_op(go_op), .go_tx(data_r),
    .go_rx(cmd_rx), .go_mack(reg_wdata[6]), .tick(half_tick), .sda_line(sda_in),
    .busy(eng_busy), .done(op_done), .byte_phase(byte_phase),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low), .ack_seen(eng_ack), .rx_byte(eng_rx)
  );

  always_comb begin
    if (cur_addr) next_code = byte_status(1'b1, data_r[0], eng_ack);
    else          next_code = byte_status(1'b0, cur_rx, cur_rx ? cur_mack : eng_ack);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0; en_r <= 1'b0; ie_r <= 1'b0; acken_r <= 1'b0;
      data_r <= '0; rate_r <= '0; ps_r <= '0; status_code <= ST_IDLE[7:3];
      txn_open <= 1'b0; addr_phase <= 1'b0; read_dir <= 1'b0;
      cur_op <= OP_START; cur_addr <= 1'b0; cur_rx <= 1'b0; cur_mack <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_r    <= reg_wdata[2];
        ie_r    <= reg_wdata[0];
        acken_r <= reg_wdata[6];
        if (reg_wdata[7]) flag <= 1'b0;
      end
      if (bus_wr && reg_addr == A_DATA) data_r <= reg_wdata;
      if (bus_wr && reg_addr == A_RATE) rate_r <= reg_wdata;
      if (bus_wr && reg_addr == A_STAT) ps_r   <= reg_wdata[PS_W-1:0];
      if (cmd_go) begin
        cur_op   <= go_op;
        cur_addr <= addr_phase;
        cur_rx   <= cmd_rx;
        cur_mack <= reg_wdata[6];
      end
      if (op_done) begin
        flag <= 1'b1;
        case (cur_op)
          OP_START: begin
            status_code <= ST_START[7:3]; txn_open <= 1'b1; addr_phase <= 1'b1;
          end
          OP_RSTART: begin
            status_code <= ST_RSTART[7:3]; txn_open <= 1'b1; addr_phase <= 1'b1;
          end
          OP_STOP: begin
            status_code <= ST_IDLE[7:3]; txn_open <= 1'b0; addr_phase <= 1'b0;
          end
          default: begin
            status_code <= next_code[7:3];
            if (cur_addr) begin
              read_dir   <= data_r[0];
              addr_phase <= 1'b0;
            end else if (cur_rx) begin
              data_r <= eng_rx;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {flag, acken_r, 3'b000, en_r, 1'b0, ie_r};
      A_DATA:  reg_rdata = data_r;
      A_RATE:  reg_rdata = rate_r;
      default: reg_rdata = {status_code, 1'b0, ps_r};
    endcase
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       flag,
  input logic       done,
  input logic [4:0] code,
  input logic       byte_phase,
  input logic       scl_low,
  input logic       sda_low,
  input logic       txn_open
);
  p_flag_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !flag);

  p_flag_rise_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(done));

  p_code_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(code));

  p_sda_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_phase && $past(byte_phase) && !$stable(sda_low)) |-> scl_low);

  p_idle_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_open && !busy) |-> (code == 5'h1F));

  p_idle_bus_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_open && !busy) |-> (!scl_low && !sda_low));
endmodule

bind i2c_byte_master i2cm_checker u_checker (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .flag(flag), .done(op_done),
  .code(status_code), .byte_phase(byte_phase), .scl_low(scl_drive_low),
  .sda_low(sda_drive_low), .txn_open(txn_open)
);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd3;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  wire  [7:0] reg_rdata;
  wire        irq, scl_low, sda_low;
  wire        scl_line, sda_line;

  always #4 clk = ~clk;

  // Slave model state
  logic       sl_sda_low;
  logic [3:0] bitcnt = 4'd15;
  logic       sl_mode_tx = 1'b0, sl_ack = 1'b0;
  logic [7:0] sl_tx = 8'h00, sl_shift = 8'h00, sl_got = 8'h00;
  logic       scl_q = 1'b1, sda_q = 1'b1;

  assign scl_line = !scl_low;
  assign sda_line = !(sda_low || sl_sda_low);

  i2c_byte_master i_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_drive_low(scl_low), .sda_drive_low(sda_low), .sda_in(sda_line)
  );

  always_comb begin
    if (bitcnt < 4'd8)       sl_sda_low = sl_mode_tx && !sl_tx[~bitcnt[2:0]];
    else if (bitcnt == 4'd8) sl_sda_low = !sl_mode_tx && sl_ack;
    else                     sl_sda_low = 1'b0;
  end

  always @(scl_line or sda_line) begin
    if (!sda_line && sda_q && scl_line && scl_q) begin
      bitcnt = 4'd15;
    end else if (!scl_line && scl_q) begin
      if (bitcnt == 4'd15 || bitcnt == 4'd8) bitcnt = 4'd0;
      else bitcnt = bitcnt + 4'd1;
    end else if (scl_line && !scl_q) begin
      if (bitcnt < 4'd8) begin
        sl_shift = {sl_shift[6:0], sda_line};
        if (bitcnt == 4'd7) sl_got = sl_shift;
      end
    end
    scl_q = scl_line;
    sda_q = sda_line;
  end

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int t0 = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  typedef struct {
    int    st;
    int    cycles;
    string req;
  } exp_t;
  exp_t exp_q[$];

  // Monitor: on each new flag (seen through irq), compare code and elapsed clocks
  logic irq_q = 1'b0;
  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n && irq && !irq_q && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk((reg_rdata & 8'hF8) == e.st, e.req, int'(reg_rdata & 8'hF8), e.st);
      chk((cyc - t0) == e.cycles, "R9", cyc - t0, e.cycles);
    end
    irq_q <= irq;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 2'd3;
  endtask

  // Driver: push the expected result, issue the command, wait for the monitor.
  task automatic cmd(input logic [7:0] v, input int st, input int halves, input int h,
                     input string req, input bit poke);
    exp_t e;
    e.st = st; e.cycles = halves * h; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = v; reg_wr = 1'b1; t0 = cyc + 1;
    @(negedge clk);
    if (poke) reg_wdata = 8'h95;
    else begin reg_wr = 1'b0; reg_addr = 2'd3; end
    if (poke) begin
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 2'd3;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    int n;
    bit irq_seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd3, d); chk(d == 8'hF8, "R1 status", d, 8'hF8);
    rd(2'd0, d); chk(d == 8'h00, "R1 control", d, 8'h00);
    chk(scl_line && sda_line, "R1 lines", {scl_line, sda_line}, 2'b11);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    wr(2'd2, 8'd2);  // half period 8 + 2 = 10

    // R3 writing 0 to the flag leaves it unchanged
    wr(2'd0, 8'h05);
    rd(2'd0, d); chk(d == 8'h05, "R3 flag write 0", d, 8'h05);

    // R2 byte command without an open transaction is ignored
    wr(2'd1, 8'h11);
    wr(2'd0, 8'h85);
    repeat (100) @(negedge clk);
    chk(irq == 1'b0, "R2 ignored byte irq", irq, 0);
    rd(2'd3, d); chk((d & 8'hF8) == 8'hF8, "R2 ignored byte status", d, 8'hF8);
    chk(scl_line == 1'b1, "R2 ignored byte bus", scl_line, 1);

    // START
    cmd(8'hA5, 8'h08, 2, 10, "R2 start", 1'b0);
    chk(!scl_line && !sda_line, "R2 start holds bus", {scl_line, sda_line}, 2'b00);

    // Address with write, acknowledged
    wr(2'd1, 8'hA0); sl_ack = 1'b1; sl_mode_tx = 1'b0;
    cmd(8'h85, 8'h18, 18, 10, "R4 addr write ack", 1'b0);
    chk(sl_got == 8'hA0, "R10 address bits", sl_got, 8'hA0);

    // Data byte acknowledged, with a STOP write during the busy period (R2: ignored)
    wr(2'd1, 8'h3C);
    cmd(8'h85, 8'h28, 18, 10, "R5 data ack", 1'b1);
    chk(sl_got == 8'h3C, "R10 data bits", sl_got, 8'h3C);
    chk(scl_line == 1'b0, "R2 write while busy ignored", scl_line, 0);

    // Data byte not acknowledged
    wr(2'd1, 8'h5A); sl_ack = 1'b0;
    cmd(8'h85, 8'h30, 18, 10, "R5 data nack", 1'b0);
    chk(sl_got == 8'h5A, "R10 data bits 2", sl_got, 8'h5A);

    // R3 writing 0 to the flag keeps it set
    wr(2'd0, 8'h05);
    rd(2'd0, d); chk(d[7] == 1'b1, "R3 flag kept", d[7], 1);
    chk(irq == 1'b1, "R11 irq with flag and ie", irq, 1);
    // R11 irq drops with interrupt enable cleared, flag still set
    wr(2'd0, 8'h04);
    chk(irq == 1'b0, "R11 irq masked", irq, 0);
    rd(2'd0, d); chk(d == 8'h84, "R11 flag still set", d, 8'h84);

    // Repeated start, then a read
    sl_ack = 1'b1;
    cmd(8'hA5, 8'h10, 4, 10, "R6 repeated start", 1'b0);
    wr(2'd1, 8'hA1);
    cmd(8'h85, 8'h40, 18, 10, "R7 addr read ack", 1'b0);
    chk(sl_got == 8'hA1, "R10 read address bits", sl_got, 8'hA1);
    sl_mode_tx = 1'b1; sl_tx = 8'hC3;
    cmd(8'hC5, 8'h50, 18, 10, "R7 data read ack", 1'b0);
    rd(2'd1, d); chk(d == 8'hC3, "R7 received byte", d, 8'hC3);
    sl_tx = 8'h96;
    cmd(8'h85, 8'h58, 18, 10, "R7 data read nack", 1'b0);
    rd(2'd1, d); chk(d == 8'h96, "R7 received byte 2", d, 8'h96);

    // STOP
    sl_mode_tx = 1'b0;
    cmd(8'h95, 8'hF8, 3, 10, "R8 stop", 1'b0);
    chk(scl_line && sda_line, "R8 lines released", {scl_line, sda_line}, 2'b11);

    // R12 prescaler in the status register; half period 8 + 1*4 = 12
    wr(2'd2, 8'd1);
    wr(2'd3, 8'h01);
    rd(2'd3, d); chk(d == 8'hF9, "R12 status layout", d, 8'hF9);

    // START with interrupts disabled, polled through the control register
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 8'hA4; reg_wr = 1'b1; t0 = cyc + 1;
    @(negedge clk);
    reg_wr = 1'b0;
    n = 0; irq_seen = 1'b0;
    while (!reg_rdata[7] && n < 2000) begin
      if (irq) irq_seen = 1'b1;
      @(negedge clk);
      n++;
    end
    chk((cyc - t0) == 24, "R9 start with prescaler", cyc - t0, 24);
    reg_addr = 2'd3;
    #1;
    chk((reg_rdata & 8'hF8) == 8'h08, "R3 status valid with flag", reg_rdata & 8'hF8, 8'h08);
    chk(!irq_seen && !irq, "R11 no irq when disabled", irq_seen | irq, 0);

    // Address write not acknowledged at the slower rate
    wr(2'd1, 8'h90); sl_ack = 1'b0;
    cmd(8'h85, 8'h20, 18, 12, "R4 addr write nack", 1'b0);
    cmd(8'hA5, 8'h10, 4, 12, "R6 repeated start 2", 1'b0);
    wr(2'd1, 8'h91);
    cmd(8'h85, 8'h48, 18, 12, "R7 addr read nack", 1'b0);
    cmd(8'h95, 8'hF8, 3, 12, "R8 stop 2", 1'b0);
    chk(scl_line && sda_line, "R8 lines released 2", {scl_line, sda_line}, 2'b11);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule